// File: doc/BRIEF.md
# MOSI Snooping Line-State Controller

This block keeps the coherence state of every line of a small cache under a four-state snooping protocol: Invalid, Shared, Owned and Modified. The local core presents read, write and eviction requests for a line index. Each request produces the bus command that the protocol needs (fill for reading, fill with ownership, upgrade-invalidate or writeback), or a hit when no bus traffic is needed. In the same cycle the block also answers one snooped bus transaction from another cache. It decides whether this cache drives the data and holds memory back, and it moves the snooped line to its new state.

The Owned state lets dirty data be handed from cache to cache without a memory write on each transfer. A Modified line that sees a foreign read keeps the dirty copy as Owned and serves every later reader. A writeback happens only when a Modified or Owned line is evicted. All outputs are combinational from the current line state and the presented request. Line states update on the next rising clock edge.

Top module: `mosi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid on `lcl_state`, with the state encoding Invalid=0, Shared=1, Owned=2, Modified=3, and `bus_cmd` is 0 (none) while no request is valid.
- R2: A local read (`req_op`=0) to an Invalid line issues `bus_cmd`=1 (fill for reading) and leaves the line Shared. A local read to a Shared, Owned or Modified line raises `lcl_hit`, issues no command and keeps the state.
- R3: A local write (`req_op`=1) to an Invalid line issues `bus_cmd`=2 (fill with ownership). A local write to a Shared or Owned line issues only `bus_cmd`=3 (upgrade-invalidate). In all three cases the line becomes Modified. A write to a Modified line is a hit with no command.
- R4: A local eviction (`req_op`=2) of a Modified or Owned line issues `bus_cmd`=4 (writeback). An evicted Shared line issues no command. In all cases the line ends Invalid.
- R5: A snooped read (`snp_op`=0) that finds the line Modified asserts `snp_supply` and moves the line to Owned.
- R6: A snooped read that finds the line Owned asserts `snp_supply` and keeps it Owned. On a Shared or Invalid line it supplies nothing and leaves the state unchanged.
- R7: A snooped read-for-ownership (`snp_op`=1) makes the line Invalid. `snp_supply` is asserted only if the line was Modified or Owned.
- R8: A snooped upgrade-invalidate (`snp_op`=2) makes the line Invalid and never asserts `snp_supply`.
- R9: `mem_inhibit` is high exactly when `snp_supply` is high.
- R10: When a valid local request and a valid snoop address the same line, `lcl_stall` is high, `bus_cmd` is 0, `lcl_hit` is low, and only the snoop changes the line.
- R11: A local request and a snoop to different lines both take effect in the same cycle.
- R12: `lcl_state` shows the current state of line `req_idx` whether or not `req_valid` is high, and `bus_idx` repeats `req_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | Local operation: 0 read, 1 write, 2 evict |
| req_idx | input | IDX_W | Line addressed by the local request |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_op | input | 2 | Snooped operation: 0 read, 1 read-for-ownership, 2 upgrade |
| snp_idx | input | IDX_W | Line addressed by the snoop |
| lcl_state | output | 2 | Current state of line `req_idx` |
| lcl_hit | output | 1 | Local read/write completes with no bus command |
| lcl_stall | output | 1 | Local request blocked by a same-line snoop |
| bus_cmd | output | 3 | Command for the bus: 0 none, 1 read, 2 read-own, 3 upgrade, 4 writeback |
| bus_idx | output | IDX_W | Line the bus command refers to |
| snp_supply | output | 1 | This cache drives data for the snooped request |
| mem_inhibit | output | 1 | Memory must not answer the snooped request |

## Verification
A line held in the wrong state shows up at the ports on the very next request to that line. A wrongly Shared line gives a hit or a silent eviction where an upgrade or a writeback is due. A wrongly Owned or Modified line asserts supply for a snoop that memory should serve. A line left Invalid issues a fill where a hit is due. Each scenario therefore ends with a probe of `lcl_state` on the touched line and a follow-up request, so that an error in a transition appears within one or two cycles of its cause.

// File: rtl/mosi_pkg.sv
package mosi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_O = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_UPG  = 3'd3,
    BC_WB   = 3'd4
  } bus_cmd_e;

  localparam logic [1:0] LOP_RD    = 2'd0;
  localparam logic [1:0] LOP_WR    = 2'd1;
  localparam logic [1:0] LOP_EVICT = 2'd2;

  localparam logic [1:0] SOP_RD  = 2'd0;
  localparam logic [1:0] SOP_RDX = 2'd1;
  localparam logic [1:0] SOP_UPG = 2'd2;

  // dirty owner: this copy must reach memory or another cache before it is dropped
  function automatic logic f_is_owner(line_st_e st);
    return (st == ST_M) || (st == ST_O);
  endfunction

  function automatic bus_cmd_e f_lcl_cmd(line_st_e st, logic [1:0] op);
    bus_cmd_e c;
    c = BC_NONE;
    case (op)
      LOP_RD:    if (st == ST_I) c = BC_RD;
      LOP_WR: begin
        if (st == ST_I) c = BC_RDX;
        else if (st == ST_S || st == ST_O) c = BC_UPG;
      end
      LOP_EVICT: if (f_is_owner(st)) c = BC_WB;
      default:   c = BC_NONE;
    endcase
    return c;
  endfunction

  function automatic line_st_e f_lcl_next(line_st_e st, logic [1:0] op);
    line_st_e n;
    n = st;
    case (op)
      LOP_RD:    if (st == ST_I) n = ST_S;
      LOP_WR:    n = ST_M;
      LOP_EVICT: n = ST_I;
      default:   n = st;
    endcase
    return n;
  endfunction

  function automatic line_st_e f_snp_next(line_st_e st, logic [1:0] op);
    line_st_e n;
    n = st;
    case (op)
      SOP_RD:  if (st == ST_M) n = ST_O;
      SOP_RDX: n = ST_I;
      SOP_UPG: n = ST_I;
      default: n = st;
    endcase
    return n;
  endfunction

  function automatic logic f_snp_supply(line_st_e st, logic [1:0] op);
    return ((op == SOP_RD) || (op == SOP_RDX)) && f_is_owner(st);
  endfunction

endpackage

// File: rtl/mosi_state_store.sv
module mosi_state_store
  import mosi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  snp_we,
  input  logic [IDX_W-1:0]      snp_idx,
  input  line_st_e              snp_nxt,
  input  logic                  lcl_we,
  input  logic [IDX_W-1:0]      lcl_idx,
  input  line_st_e              lcl_nxt,
  output logic [LINES-1:0][1:0] st_vec
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_snp;
    logic hit_lcl;
    assign hit_snp = snp_we && (snp_idx == IDX_W'(g));
    assign hit_lcl = lcl_we && (lcl_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_vec[g] <= ST_I;
      else if (hit_snp) st_vec[g] <= snp_nxt;
      else if (hit_lcl) st_vec[g] <= lcl_nxt;
    end
  end

  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_we && lcl_we && (snp_idx == lcl_idx))); // R10

endmodule

// File: rtl/mosi_local_fsm.sv
module mosi_local_fsm
  import mosi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  line_st_e   st,
  input  logic [1:0] op,
  output bus_cmd_e   cmd,
  output line_st_e   nxt,
  output logic       we,
  output logic       hit
);

  logic is_access;
  assign is_access = (op == LOP_RD) || (op == LOP_WR);

  always_comb begin
    cmd = BC_NONE;
    nxt = st;
    we  = 1'b0;
    hit = 1'b0;
    if (en) begin
      cmd = f_lcl_cmd(st, op);
      nxt = f_lcl_next(st, op);
      we  = 1'b1;
      hit = is_access && (cmd == BC_NONE);
    end
  end

  AST_FILL_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == BC_RD || cmd == BC_RDX) |-> (st == ST_I)); // R2

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == BC_WB) |-> (st == ST_M || st == ST_O)); // R4

endmodule

// File: rtl/mosi_snoop_resp.sv
module mosi_snoop_resp
  import mosi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  line_st_e   st,
  input  logic [1:0] op,
  output line_st_e   nxt,
  output logic       we,
  output logic       supply,
  output logic       inhibit
);

  logic dirty;
  logic wants_data;
  assign dirty      = (st == ST_M) || (st == ST_O);
  assign wants_data = (op != SOP_UPG) && (op != 2'd3);

  always_comb begin
    nxt    = st;
    we     = 1'b0;
    supply = 1'b0;
    if (valid) begin
      nxt    = f_snp_next(st, op);
      we     = 1'b1;
      supply = f_snp_supply(st, op);
    end
  end

  // memory is held back whenever a dirty copy here will answer
  assign inhibit = valid && dirty && wants_data;

  AST_UPG_NEVER_SUPPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == SOP_UPG) |-> !supply); // R8

  AST_CLEAN_NEVER_SUPPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_S || st == ST_I) |-> !supply); // R6

endmodule

// File: rtl/mosi_line_ctrl.sv
module mosi_line_ctrl
  import mosi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             snp_valid,
  input  logic [1:0]       snp_op,
  input  logic [IDX_W-1:0] snp_idx,
  output logic [1:0]       lcl_state,
  output logic             lcl_hit,
  output logic             lcl_stall,
  output logic [2:0]       bus_cmd,
  output logic [IDX_W-1:0] bus_idx,
  output logic             snp_supply,
  output logic             mem_inhibit
);

  logic [LINES-1:0][1:0] st_vec;
  line_st_e rd_st;
  line_st_e sn_st;
  logic     collide;
  logic     lcl_en;

  bus_cmd_e lcl_cmd;
  line_st_e lcl_nxt;
  logic     lcl_we;
  line_st_e snp_nxt;
  logic     snp_we;

  assign rd_st   = line_st_e'(st_vec[req_idx]);
  assign sn_st   = line_st_e'(st_vec[snp_idx]);
  assign collide = req_valid && snp_valid && (req_idx == snp_idx);
  assign lcl_en  = req_valid && !collide;

  mosi_local_fsm u_lcl (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (lcl_en),
    .st    (rd_st),
    .op    (req_op),
    .cmd   (lcl_cmd),
    .nxt   (lcl_nxt),
    .we    (lcl_we),
    .hit   (lcl_hit)
  );

  mosi_snoop_resp u_snp (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (snp_valid),
    .st      (sn_st),
    .op      (snp_op),
    .nxt     (snp_nxt),
    .we      (snp_we),
    .supply  (snp_supply),
    .inhibit (mem_inhibit)
  );

  mosi_state_store #(.LINES(LINES), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .snp_we  (snp_we),
    .snp_idx (snp_idx),
    .snp_nxt (snp_nxt),
    .lcl_we  (lcl_we),
    .lcl_idx (req_idx),
    .lcl_nxt (lcl_nxt),
    .st_vec  (st_vec)
  );

  assign lcl_state = rd_st;
  assign lcl_stall = collide;
  assign bus_cmd   = lcl_cmd;
  assign bus_idx   = req_idx;

  AST_INHIBIT_TRACKS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_inhibit == snp_supply); // R9

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_stall |-> (bus_cmd == BC_NONE && !lcl_hit)); // R10

  AST_MOD_READ_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == SOP_RD && sn_st == ST_M) |=> (st_vec[$past(snp_idx)] == ST_O)); // R5

  AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_WB) |=> (st_vec[$past(bus_idx)] == ST_I)); // R4

  AST_UPG_FROM_SHARER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_UPG) |-> (rd_st == ST_S || rd_st == ST_O)); // R3

  AST_OWN_GAINS_M: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_RDX || bus_cmd == BC_UPG) |=> (st_vec[$past(bus_idx)] == ST_M)); // R3

endmodule

// File: tb/mosi_line_ctrl_tb_top.sv
module mosi_line_ctrl_tb_top;

  localparam int LINES = 8;
  localparam int IDX_W = 3;

  localparam logic [1:0] I = 2'd0, S = 2'd1, O = 2'd2, M = 2'd3;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EV = 2'd2;
  localparam logic [1:0] SRD = 2'd0, SRDX = 2'd1, SUPG = 2'd2;
  localparam logic [2:0] C_NONE = 3'd0, C_RD = 3'd1, C_RDX = 3'd2, C_UPG = 3'd3, C_WB = 3'd4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [1:0]       req_op = 2'd0;
  logic [IDX_W-1:0] req_idx = '0;
  logic             snp_valid = 1'b0;
  logic [1:0]       snp_op = 2'd0;
  logic [IDX_W-1:0] snp_idx = '0;
  logic [1:0]       lcl_state;
  logic             lcl_hit;
  logic             lcl_stall;
  logic [2:0]       bus_cmd;
  logic [IDX_W-1:0] bus_idx;
  logic             snp_supply;
  logic             mem_inhibit;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mosi_line_ctrl #(.LINES(LINES), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
    .lcl_state(lcl_state), .lcl_hit(lcl_hit), .lcl_stall(lcl_stall),
    .bus_cmd(bus_cmd), .bus_idx(bus_idx),
    .snp_supply(snp_supply), .mem_inhibit(mem_inhibit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic probe(input logic [IDX_W-1:0] idx, input logic [1:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b0; snp_valid = 1'b0; req_idx = idx;
    #1;
    chk(lcl_state == exp, req, lcl_state, exp);
  endtask

  // local request: check command, hit and echo index, then let the edge pass
  task automatic lcl(input logic [1:0] op, input logic [IDX_W-1:0] idx,
                     input logic [2:0] exp_cmd, input bit exp_hit, input string req);
    @(negedge clk);
    snp_valid = 1'b0;
    req_valid = 1'b1; req_op = op; req_idx = idx;
    #1;
    chk(bus_cmd == exp_cmd, req, bus_cmd, exp_cmd);
    chk(lcl_hit == exp_hit, req, lcl_hit, exp_hit);
    chk(bus_idx == idx, "R12", bus_idx, idx);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic snp(input logic [1:0] op, input logic [IDX_W-1:0] idx,
                     input bit exp_sup, input string req);
    @(negedge clk);
    req_valid = 1'b0;
    snp_valid = 1'b1; snp_op = op; snp_idx = idx;
    #1;
    chk(snp_supply == exp_sup, req, snp_supply, exp_sup);
    chk(mem_inhibit == exp_sup, "R9", mem_inhibit, exp_sup);
    @(posedge clk);
    #1 snp_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < LINES; i++) probe(i[IDX_W-1:0], I, "R1");
    #1 chk(bus_cmd == C_NONE, "R1", bus_cmd, C_NONE);
  endtask

  task automatic t_read_paths;
    lcl(RD, 3'd0, C_RD, 1'b0, "R2");
    probe(3'd0, S, "R2");
    lcl(RD, 3'd0, C_NONE, 1'b1, "R2");
    probe(3'd0, S, "R2");
  endtask

  task automatic t_write_paths;
    lcl(WR, 3'd1, C_RDX, 1'b0, "R3");
    probe(3'd1, M, "R3");
    lcl(WR, 3'd1, C_NONE, 1'b1, "R3");
    lcl(RD, 3'd1, C_NONE, 1'b1, "R2");
    probe(3'd1, M, "R2");
    lcl(WR, 3'd0, C_UPG, 1'b0, "R3");
    probe(3'd0, M, "R3");
  endtask

  task automatic t_owned;
    snp(SRD, 3'd1, 1'b1, "R5");
    probe(3'd1, O, "R5");
    snp(SRD, 3'd1, 1'b1, "R6");
    probe(3'd1, O, "R6");
    lcl(RD, 3'd1, C_NONE, 1'b1, "R2");
    probe(3'd1, O, "R2");
    lcl(WR, 3'd1, C_UPG, 1'b0, "R3");
    probe(3'd1, M, "R3");
  endtask

  task automatic t_snoop_invalidate;
    snp(SRDX, 3'd1, 1'b1, "R7");
    probe(3'd1, I, "R7");
    snp(SRD, 3'd0, 1'b1, "R5");
    snp(SRDX, 3'd0, 1'b1, "R7");
    probe(3'd0, I, "R7");
    lcl(RD, 3'd2, C_RD, 1'b0, "R2");
    snp(SRD, 3'd2, 1'b0, "R6");
    probe(3'd2, S, "R6");
    snp(SRDX, 3'd2, 1'b0, "R7");
    probe(3'd2, I, "R7");
    snp(SRD, 3'd2, 1'b0, "R6");
    probe(3'd2, I, "R6");
    lcl(WR, 3'd3, C_RDX, 1'b0, "R3");
    snp(SRD, 3'd3, 1'b1, "R5");
    snp(SUPG, 3'd3, 1'b0, "R8");
    probe(3'd3, I, "R8");
    lcl(RD, 3'd3, C_RD, 1'b0, "R2");
    snp(SUPG, 3'd3, 1'b0, "R8");
    probe(3'd3, I, "R8");
  endtask

  task automatic t_evict;
    lcl(WR, 3'd4, C_RDX, 1'b0, "R3");
    lcl(EV, 3'd4, C_WB, 1'b0, "R4");
    probe(3'd4, I, "R4");
    lcl(WR, 3'd4, C_RDX, 1'b0, "R3");
    snp(SRD, 3'd4, 1'b1, "R5");
    lcl(EV, 3'd4, C_WB, 1'b0, "R4");
    probe(3'd4, I, "R4");
    lcl(RD, 3'd4, C_RD, 1'b0, "R2");
    lcl(EV, 3'd4, C_NONE, 1'b0, "R4");
    probe(3'd4, I, "R4");
    lcl(EV, 3'd4, C_NONE, 1'b0, "R4");
    probe(3'd4, I, "R4");
  endtask

  task automatic t_collide;
    lcl(WR, 3'd5, C_RDX, 1'b0, "R3");
    @(negedge clk);
    req_valid = 1'b1; req_op = EV; req_idx = 3'd5;
    snp_valid = 1'b1; snp_op = SRD; snp_idx = 3'd5;
    #1;
    chk(lcl_stall == 1'b1, "R10", lcl_stall, 1);
    chk(bus_cmd == C_NONE, "R10", bus_cmd, C_NONE);
    chk(lcl_hit == 1'b0, "R10", lcl_hit, 0);
    chk(snp_supply == 1'b1, "R10", snp_supply, 1);
    @(posedge clk);
    #1 begin req_valid = 1'b0; snp_valid = 1'b0; end
    probe(3'd5, O, "R10");
    // different lines: both act in one cycle
    @(negedge clk);
    req_valid = 1'b1; req_op = WR; req_idx = 3'd6;
    snp_valid = 1'b1; snp_op = SRDX; snp_idx = 3'd5;
    #1;
    chk(lcl_stall == 1'b0, "R11", lcl_stall, 0);
    chk(bus_cmd == C_RDX, "R11", bus_cmd, C_RDX);
    chk(snp_supply == 1'b1, "R11", snp_supply, 1);
    @(posedge clk);
    #1 begin req_valid = 1'b0; snp_valid = 1'b0; end
    probe(3'd6, M, "R11");
    probe(3'd5, I, "R11");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_read_paths();
        t_write_paths();
        t_owned();
        t_snoop_invalidate();
        t_evict();
        t_collide();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule